// File: doc/BRIEF.md
# Keyed Watchdog Timer With Disable Lockout

The block is a watchdog counter clocked by the system clock. If software does not restart it in time, it raises a reset request. Software reaches it through one 8-bit write port and one 8-bit read port. A few reserved command bytes act on it:

- One byte restarts the count and also turns the watchdog on if it was stopped.
- A two-byte key with a short deadline stops the watchdog.
- Another byte locks the stop path until the next reset.

A write with bit 7 low sets a 3-bit interval code. The code selects a timeout of 4^(3+code) clock periods, which ranges from 64 to 1,048,576 clocks.

When the count expires, the reset request is driven as a one-clock pulse. The count then starts again from zero, so the block keeps producing periodic requests until it is restarted or stopped. Producing the actual system reset is left to the surrounding logic.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is active, the interval code is 111b, `rd_data` reads 0x17 and `wdt_rst_req` is low.
- R2: Writing 0xA5 makes the watchdog active (read bit 4 = 1) and restarts its count from zero.
- R3: Writing 0xDE and then 0xAD on one of the next 4 clock edges stops the watchdog (read bit 4 = 0). If 0xAD comes on the 5th edge or later, it has no effect.
- R4: Any other write between 0xDE and 0xAD cancels the key, and the later 0xAD leaves the watchdog active.
- R5: Writing 0xFF sets a lock. While the lock is set, the 0xDE/0xAD key has no effect. Only reset clears the lock.
- R6: A write with bit 7 = 0 loads the interval code from bits 2:0. A read returns the code in bits 2:0 and the active status in bit 4, with bits 7:5 and bit 3 reading 0.
- R7: With code c, `wdt_rst_req` pulses high for exactly one clock, 4^(3+c) clock edges after the last restart. The count then restarts by itself, so the pulses repeat with that period.
- R8: While the watchdog is stopped, `wdt_rst_req` never pulses.
- R9: A write of a byte with bit 7 = 1 that is not 0xA5, 0xDE, 0xAD or 0xFF changes neither the code nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte |
| rd_data | output | 8 | Readback: bit 4 status, bits 2:0 interval code |
| wdt_rst_req | output | 1 | One-clock reset request pulse on timeout |

## Verification
A back-to-back stream of control bytes checks the key logic four ways:
- a clean 0xDE/0xAD pair;
- a pair broken by an interval write;
- a pair broken by a non-command byte;
- a pair attempted while the lock is set.

Each readback then shows whether the status bit moved. The stop deadline is probed with 0xAD placed on the 4th and then the 5th edge after 0xDE. The exact timeout is measured in edges for codes 0 and 2, both after a restart and between repeated pulses, which separates an off-by-one limit from a wrong exponent. A restart in mid-count checks that the count is reloaded.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] CMD_KICK    = 8'hA5;
  localparam logic [7:0] CMD_KEY_ONE = 8'hDE;
  localparam logic [7:0] CMD_KEY_TWO = 8'hAD;
  localparam logic [7:0] CMD_LOCK    = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_KICK,
    OP_KEY,
    OP_LOCK
  } kwd_op_e;
endpackage

// File: rtl/kwd_cmd_fsm.sv
module kwd_cmd_fsm
  import kwd_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int KEY_WIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              active_q,
  output logic              lock_q,
  output logic [CODE_W-1:0] code_q,
  output logic              kick
);
  localparam int WIN_W = $clog2(KEY_WIN + 1);

  logic              active_d, lock_d;
  logic [CODE_W-1:0] code_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic              key_armed;

  assign key_armed = (win_q != '0);
  assign kick      = wr_en && (wr_data == CMD_KICK);

  always_comb begin
    active_d = active_q;
    lock_d   = lock_q;
    code_d   = code_q;
    win_d    = key_armed ? win_q - WIN_W'(1) : '0;
    if (wr_en) begin
      win_d = '0;
      if (!wr_data[7]) begin
        code_d = wr_data[CODE_W-1:0];
      end else begin
        unique case (wr_data)
          CMD_KICK:    active_d = 1'b1;
          CMD_LOCK:    lock_d   = 1'b1;
          CMD_KEY_ONE: if (!lock_q) win_d = WIN_W'(KEY_WIN);
          CMD_KEY_TWO: if (!lock_q && key_armed) active_d = 1'b0;
          default:     ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      lock_q   <= 1'b0;
      code_q   <= '1;
      win_q    <= '0;
    end else begin
      active_q <= active_d;
      lock_q   <= lock_d;
      code_q   <= code_d;
      win_q    <= win_d;
    end
  end
endmodule

// File: rtl/kwd_limit_table.sv
module kwd_limit_table #(
  parameter int CNT_W    = 21,
  parameter int CODE_W   = 3,
  parameter int EXP_BASE = 3,
  parameter int EXP_STEP = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  lim_m1
);
  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] tab [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_lim
    localparam int EXPO = EXP_STEP * (EXP_BASE + g);
    assign tab[g] = CNT_W'((64'd1 << EXPO) - 64'd1);
  end

  assign lim_m1 = tab[code];
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] lim_m1,
  output logic             req_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire, req_d;

  assign expire = run && !reload && (cnt_q >= lim_m1);

  always_comb begin
    req_d = expire;
    if (!run || reload || expire) cnt_d = '0;
    else                          cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W    = 21,
  parameter int CODE_W   = 3,
  parameter int EXP_BASE = 3,
  parameter int EXP_STEP = 2,
  parameter int KEY_WIN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_rst_req
);
  localparam int MAX_EXP = EXP_STEP * (EXP_BASE + (1 << CODE_W) - 1);
  localparam bit FITS    = (MAX_EXP < CNT_W) && (CODE_W <= 3);

  logic [1:0]        sync_q;
  logic              rst_sync_n;
  logic              active_q, lock_q, kick;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim_m1;

  initial begin
    if (!FITS) $error("keyed_watchdog: counter too narrow for largest interval");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  kwd_cmd_fsm #(.CODE_W(CODE_W), .KEY_WIN(KEY_WIN)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .active_q (active_q),
    .lock_q   (lock_q),
    .code_q   (code_q),
    .kick     (kick)
  );

  kwd_limit_table #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .EXP_BASE(EXP_BASE), .EXP_STEP(EXP_STEP)
  ) u_lim (
    .code   (code_q),
    .lim_m1 (lim_m1)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (active_q),
    .reload (kick),
    .lim_m1 (lim_m1),
    .req_q  (wdt_rst_req)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[4]           = active_q;
    rd_data[CODE_W-1:0]  = code_q;
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       req,
  input logic       active,
  input logic       locked
);
  logic odd_cmd;
  assign odd_cmd = wr_en && wr_data[7] && (wr_data != 8'hA5) && (wr_data != 8'hDE)
                   && (wr_data != 8'hAD) && (wr_data != 8'hFF);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  assert_quiet_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(active));

  assert_kick_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hA5) |=> rd_data[4]);

  assert_lock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hFF) |=> locked);

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_locked_stays_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && active) |=> active);

  assert_code_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> (rd_data[2:0] == $past(wr_data[2:0])));

  assert_odd_byte_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    odd_cmd |=> $stable(rd_data));
endmodule

bind keyed_watchdog kwd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .req     (wdt_rst_req),
  .active  (active_q),
  .locked  (lock_q)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {byte written, expected readback after it}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 8'h10}, {8'h03, 8'h13}, {8'hDE, 8'h13}, {8'hAD, 8'h03},
    {8'hA5, 8'h13}, {8'hDE, 8'h13}, {8'h55, 8'h15}, {8'hAD, 8'h15},
    {8'hDE, 8'h15}, {8'hC3, 8'h15}, {8'hAD, 8'h15}, {8'h06, 8'h16}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_rst_req;
  int         checks = 0;
  int         fails = 0;
  int         req_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  // edges counted from the current negedge until the request is seen high
  task automatic edges_to_pulse(output int n);
    n = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (wdt_rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    int n;
    do_reset();
    // R1 reset state
    check("R1 readback", rd_data, 8'h17);
    check("R1 no request", wdt_rst_req, 0);

    // back-to-back byte stream: R2 R3 R4 R6 R9
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      wr_en = 1'b1;
      wr_data = VEC[v][15:8];
      @(negedge clk);
      check($sformatf("R3/R4/R6/R9 vec%0d", v), rd_data, VEC[v][7:0]);
    end
    wr_en = 1'b0;
    check("R7 no early request", req_seen, 0);

    // R7 timeout with code 0 = 64 edges, then periodic
    wr(8'h00); wr(8'hA5);
    edges_to_pulse(n);
    check("R7 code0 first", n, 64);
    @(negedge clk);
    check("R7 one clock wide", wdt_rst_req, 0);
    edges_to_pulse(n);
    check("R7 code0 period", n, 63);

    // R2 mid-count restart
    wr(8'hA5); idle(40); wr(8'hA5);
    edges_to_pulse(n);
    check("R2 reload restarts", n, 64);

    // R7 code 2 = 1024 edges
    wr(8'h02); wr(8'hA5);
    edges_to_pulse(n);
    check("R7 code2", n, 1024);

    // R3 deadline: 0xAD on 4th edge stops
    wr(8'h00); wr(8'hA5); wr(8'hDE); idle(2); wr(8'hAD);
    check("R3 4th edge stops", rd_data[4], 0);
    // R8 stopped: no pulse
    req_seen = 0;
    idle(300);
    check("R8 no request while stopped", req_seen, 0);
    // R3 5th edge too late
    wr(8'hA5); wr(8'hDE); idle(3); wr(8'hAD);
    check("R3 5th edge late", rd_data[4], 1);

    // R5 lock
    wr(8'hFF); wr(8'hDE); wr(8'hAD);
    check("R5 key blocked", rd_data[4], 1);
    wr(8'hA5);
    edges_to_pulse(n);
    check("R5 still times out", n, 64);
    do_reset();
    check("R1 after reset", rd_data, 8'h17);
    wr(8'hDE); wr(8'hAD);
    check("R5 reset clears lock", rd_data[4], 0);
    wr(8'h81);
    check("R9 odd byte", rd_data, 8'h07);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(negedge clk) if (wdt_rst_req) req_seen++;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule